// File: doc/BRIEF.md
# Multi-Pin GPIO Controller with Interrupt Detection

This block is a register-mapped general-purpose I/O controller for a parameterized number of pins (eight by default). Software reaches it over a simple 32-bit read/write bus that uses word addresses. Each pin owns its own register window, and each window holds four words:

- a setup word with the output-enable bit;
- a data word that reports the synchronized input level and holds the driven output value;
- an event-control word;
- a pending word.

Every pin input passes through a two-flop synchronizer. A one-cycle-delayed copy of the synchronized value lets the block detect rising edges, falling edges, both edges, or an active level for each pin.

When an event occurs and raw capture is enabled for that pin, the pin's pending flag is set. The flag stays set until software writes it back with bit 0 equal to 0. The pending flags of all pins whose interrupt-enable bit is set are ORed into a single registered interrupt line. Each window is 0x1000 bytes apart, so the pin index sits in the upper word-address bits.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: `bus_addr` is a word address (byte offset divided by four). Bits [ADDR_W-1:10] select the pin. Bits [1:0] select the word: 0 is setup, 1 is data, 2 is event-control and 3 is pending. An access with any of bits [9:2] nonzero reads zero and writes nothing.
- R2: After reset, every register reads zero, and `pin_oe`, `pin_out` and `irq_out` are all 0.
- R3: Setup bit 9 drives `pin_oe` for that pin. Data bit 1 drives `pin_out`. Both outputs follow the edge at which the write is accepted.
- R4: Data bit 0 reads the pin input after a two-flop synchronizer, so a read issued one cycle after an input change still returns the old level. Bit 0 is read-only, and writes to it are ignored.
- R5: Event-control bit 4 (raw capture) must be 1 for any event to set the pending flag. Bit 0 (interrupt enable) plays no part in capture.
- R6: Event-control bits 3:2 select the detection mode: 0 is level, 1 is rising, 2 is falling, 3 is both edges. Bit 1 is the polarity. In level mode, polarity 1 is active-high and polarity 0 is active-low. In the single-edge modes, polarity 1 senses the named edge and polarity 0 senses the opposite edge. In both-edges mode the polarity bit is ignored.
- R7: Writing the pending word with bit 0 = 0 clears the flag, and that clear wins over an event in the same cycle. Writing bit 0 = 1 has no effect. In level mode, a persisting active level sets the flag again on the cycle after the clear.
- R8: `irq_out` is registered, and it is 1 exactly one cycle after any pin has both its pending flag and its event-control bit 0 set.
- R9: An access to a pin index at or above NUM_PINS reads zero and changes no state.
- R10: Unused bits of every word read zero. Event-control bits 7:5 (routing target) are stored and read back but do not affect detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe; `bus_rdata` updates at the next edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| irq_out | output | 1 | Summary interrupt |

## Verification
A wrong pending state appears on `irq_out` two edges after the event that should have set it. It also appears on the next read of the pending word.

A synchronizer that is one stage short returns the new level on a read issued one cycle after an input change. Mis-decoded polarity or mode either sets a flag on the wrong edge or leaves it clear, and this is visible within five cycles of the stimulus.

A clear that loses to a level event keeps `irq_out` high in the cycle after the clear, where it should drop for exactly one cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  typedef enum logic [1:0] {
    REG_SETUP = 2'd0,
    REG_DATA  = 2'd1,
    REG_EVCFG = 2'd2,
    REG_PEND  = 2'd3
  } reg_sel_e;

  localparam int OE_BIT    = 9;
  localparam int OUT_BIT   = 1;
  localparam int IN_BIT    = 0;
  localparam int PEND_BIT  = 0;
  localparam int EVCFG_W   = 8;
  localparam int WIN_LSB   = 10;  // word-address bit where the pin index starts

  // Packed MSB first: target[7:5], raw[4], det[3:2], pol[1], en[0]
  typedef struct packed {
    logic [2:0] target;
    logic       raw_en;
    det_mode_e  det;
    logic       pol;
    logic       en;
  } evcfg_t;

  function automatic logic detect_event(det_mode_e m, logic pol, logic s, logic p);
    logic rise;
    logic fall;
    rise = s & ~p;
    fall = ~s & p;
    case (m)
      DET_LEVEL: return pol ? s : ~s;
      DET_RISE:  return pol ? rise : fall;
      DET_FALL:  return pol ? fall : rise;
      default:   return rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  input  logic        sync_in,
  input  logic        prev_in,
  output logic        oe_o,
  output logic        out_o,
  output logic        irq_en_o,
  output logic        pend_o,
  output logic [31:0] rd_word_o
);
  logic   oe_q;
  logic   out_q;
  logic   pend_q;
  evcfg_t evcfg_q;
  logic   ev_hit;
  logic   sw_clear;

  always_comb begin
    ev_hit   = evcfg_q.raw_en && detect_event(evcfg_q.det, evcfg_q.pol, sync_in, prev_in);
    sw_clear = wr_en && (sel == REG_PEND) && !wdata[PEND_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      evcfg_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          REG_SETUP: oe_q    <= wdata[OE_BIT];
          REG_DATA:  out_q   <= wdata[OUT_BIT];
          REG_EVCFG: evcfg_q <= evcfg_t'(wdata[EVCFG_W-1:0]);
          default: ;
        endcase
      end
      // software clear takes priority over a same-cycle hardware event
      if (sw_clear)
        pend_q <= 1'b0;
      else if (ev_hit)
        pend_q <= 1'b1;
    end
  end

  always_comb begin
    rd_word_o = '0;
    case (sel)
      REG_SETUP: rd_word_o[OE_BIT] = oe_q;
      REG_DATA: begin
        rd_word_o[IN_BIT]  = sync_in;
        rd_word_o[OUT_BIT] = out_q;
      end
      REG_EVCFG: rd_word_o[EVCFG_W-1:0] = evcfg_q;
      default:   rd_word_o[PEND_BIT] = pend_q;
    endcase
  end

  assign oe_o     = oe_q;
  assign out_o    = out_q;
  assign irq_en_o = evcfg_q.en;
  assign pend_o   = pend_q;

  // R5: the flag can only rise when raw capture was enabled
  a_r5_raw_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(evcfg_q.raw_en));

  // R7: a zero write to the pending word always leaves it clear
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == REG_PEND && !wdata[PEND_BIT]) |=> !pend_q);

  // R6: in edge modes a new flag needs an input transition
  a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    ($rose(pend_q) && $past(evcfg_q.det) != DET_LEVEL) |-> $past(sync_in != prev_in));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] en_i,
  output logic                irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend_i & en_i);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);
  localparam int PIN_AW = ADDR_W - WIN_LSB;
  localparam int GAP_W  = WIN_LSB - 2;

  logic [PIN_AW-1:0]   pin_idx;
  logic [GAP_W-1:0]    gap_bits;
  reg_sel_e            sel;
  logic                hit;
  logic [NUM_PINS-1:0] sync_v;
  logic [NUM_PINS-1:0] prev_v;
  logic [NUM_PINS-1:0] pend_v;
  logic [NUM_PINS-1:0] ien_v;
  logic [31:0]         rd_words [NUM_PINS];
  logic [31:0]         rd_mux;

  always_comb begin
    pin_idx  = bus_addr[ADDR_W-1:WIN_LSB];
    gap_bits = bus_addr[WIN_LSB-1:2];
    sel      = reg_sel_e'(bus_addr[1:0]);
    hit      = (gap_bits == '0) && (32'(pin_idx) < NUM_PINS);
  end

  gpio_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_in),
    .sync_o  (sync_v),
    .prev_o  (prev_v)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic slice_wr;
    assign slice_wr = bus_wr_en && hit && (pin_idx == PIN_AW'(g));
    gpio_pin_slice i_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (slice_wr),
      .sel       (sel),
      .wdata     (bus_wdata),
      .sync_in   (sync_v[g]),
      .prev_in   (prev_v[g]),
      .oe_o      (pin_oe[g]),
      .out_o     (pin_out[g]),
      .irq_en_o  (ien_v[g]),
      .pend_o    (pend_v[g]),
      .rd_word_o (rd_words[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (hit && pin_idx == PIN_AW'(i)) rd_mux = rd_words[i];
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) i_merge (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_v),
    .en_i   (ien_v),
    .irq_o  (irq_out)
  );

  // R8: the summary line only rises after an enabled pending flag
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|(pend_v & ien_v)));

  // R9: a write that misses every window leaves the pin outputs alone
  a_r9_miss_no_effect: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && !hit) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R2: outputs are quiet in the cycle after reset
  a_r2_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq_out));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int N  = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(AW)) i_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  function automatic logic [AW-1:0] wa(input int pin, input int sel);
    return AW'((pin << 10) | sel);
  endfunction

  // event-control word: target[7:5] raw[4] det[3:2] pol[1] en[0]
  function automatic logic [31:0] evw(input int tgt, input bit raw, input int det,
                                      input bit pol, input bit en);
    return 32'((tgt << 5) | (int'(raw) << 4) | (det << 2) | (int'(pol) << 1) | int'(en));
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_a(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_pin(input int p, input bit v);
    @(negedge clk);
    pin_in[p] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic clean(input int p);
    wr_a(wa(p, 2), 32'h0);
    wr_a(wa(p, 3), 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R2 pin_oe", 32'(pin_oe), 32'h0);
    check("R2 pin_out", 32'(pin_out), 32'h0);
    check("R2 irq_out", 32'(irq_out), 32'h0);
    for (int s = 0; s < 4; s++) begin
      rd_a(wa(3, s), d);
      check("R2 register zero", d, 32'h0);
    end
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr_a(wa(0, 0), 32'hFFFF_FFFF);
    rd_a(wa(0, 0), d);
    check("R10 setup unused bits", d, 32'h200);
    check("R3 pin_oe bit 9", 32'(pin_oe), 32'h1);
    wr_a(wa(5, 1), 32'h2);
    check("R3 pin_out follows data bit 1", 32'(pin_out), 32'h20);
    rd_a(wa(5, 1), d);
    check("R1 data word of pin 5", d, 32'h2);
    wr_a(wa(2, 2), evw(5, 1'b0, 1, 1'b1, 1'b0));
    rd_a(wa(2, 2), d);
    check("R10 event-control readback", d, 32'hA6);
    rd_a(wa(2, 3), d);
    check("R10 target has no effect", d, 32'h0);
    wr_a(wa(0, 0) | AW'(4), 32'h0);
    check("R1 gap bits ignore write", 32'(pin_oe), 32'h1);
    rd_a(wa(0, 0) | AW'(4), d);
    check("R1 gap bits read zero", d, 32'h0);
    wr_a(wa(0, 0), 32'h0);
    wr_a(wa(5, 1), 32'h0);
    check("R3 outputs cleared", 32'({pin_oe, pin_out}), 32'h0);
    clean(2);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk);
    pin_in[1] = 1'b1;
    rd_a(wa(1, 1), d);
    check("R4 two-flop latency old level", d, 32'h0);
    rd_a(wa(1, 1), d);
    check("R4 synchronized level", d, 32'h1);
    wr_a(wa(6, 1), 32'h1);
    rd_a(wa(6, 1), d);
    check("R4 input bit read-only", d, 32'h0);
    set_pin(1, 1'b0);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    wr_a(wa(1, 2), evw(0, 1'b0, 1, 1'b1, 1'b1));
    set_pin(1, 1'b1);
    rd_a(wa(1, 3), d);
    check("R5 no capture without raw", d, 32'h0);
    check("R5 no irq without raw", 32'(irq_out), 32'h0);
    set_pin(1, 1'b0);
    wr_a(wa(1, 2), evw(0, 1'b1, 1, 1'b1, 1'b0));
    set_pin(1, 1'b1);
    rd_a(wa(1, 3), d);
    check("R5 capture with enable clear", d, 32'h1);
    check("R8 irq masked by enable", 32'(irq_out), 32'h0);
    wr_a(wa(1, 2), evw(0, 1'b1, 1, 1'b1, 1'b1));
    @(negedge clk);
    check("R8 irq after enable", 32'(irq_out), 32'h1);
    wr_a(wa(1, 3), 32'h1);
    rd_a(wa(1, 3), d);
    check("R7 write one keeps flag", d, 32'h1);
    wr_a(wa(1, 3), 32'h0);
    rd_a(wa(1, 3), d);
    check("R7 write zero clears", d, 32'h0);
    clean(1);
    set_pin(1, 1'b0);
    wr_a(wa(1, 3), 32'h1);
    rd_a(wa(1, 3), d);
    check("R7 software cannot set", d, 32'h0);
  endtask

  task automatic t_edge(input int p, input int det, input bit pol,
                        input bit exp_rise, input bit exp_fall, input string req);
    logic [31:0] d;
    wr_a(wa(p, 2), evw(0, 1'b1, det, pol, 1'b0));
    set_pin(p, 1'b1);
    rd_a(wa(p, 3), d);
    check({req, " rising input"}, d, 32'(exp_rise));
    wr_a(wa(p, 3), 32'h0);
    set_pin(p, 1'b0);
    rd_a(wa(p, 3), d);
    check({req, " falling input"}, d, 32'(exp_fall));
    clean(p);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr_a(wa(7, 2), evw(0, 1'b1, 0, 1'b0, 1'b0));
    @(negedge clk);
    rd_a(wa(7, 3), d);
    check("R6 level active-low on low input", d, 32'h1);
    clean(7);
    wr_a(wa(2, 2), evw(0, 1'b1, 0, 1'b1, 1'b1));
    @(negedge clk);
    rd_a(wa(2, 3), d);
    check("R6 level active-high idle low", d, 32'h0);
    set_pin(2, 1'b1);
    check("R8 irq from level", 32'(irq_out), 32'h1);
    wr_a(wa(2, 3), 32'h0);
    @(negedge clk);
    check("R7 clear wins, irq drops one cycle", 32'(irq_out), 32'h0);
    repeat (2) @(negedge clk);
    check("R7 level re-asserts irq", 32'(irq_out), 32'h1);
    rd_a(wa(2, 3), d);
    check("R7 level re-asserts flag", d, 32'h1);
    clean(2);
    set_pin(2, 1'b0);
  endtask

  task automatic t_oor;
    logic [31:0] d;
    wr_a(wa(9, 0), 32'h200);
    wr_a(wa(N, 1), 32'h2);
    check("R9 out-of-range write ignored", 32'({pin_oe, pin_out}), 32'h0);
    rd_a(wa(N, 0), d);
    check("R9 out-of-range read zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_input();
    t_raw();
    t_edge(3, 1, 1'b1, 1'b1, 1'b0, "R6 rise pol1");
    t_edge(4, 2, 1'b1, 1'b0, 1'b1, "R6 fall pol1");
    t_edge(5, 1, 1'b0, 1'b0, 1'b1, "R6 rise pol0");
    t_edge(6, 3, 1'b0, 1'b1, 1'b1, "R6 both pol ignored");
    t_level();
    t_oor();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule